// File: doc/BRIEF.md
# Address-Pin GPIO Multiplexer

This block lets each line of a 16-bit external-memory address bus work either as an address output or as a general-purpose I/O pin. Three 16-bit registers on a simple synchronous register port set the behaviour. A select register picks GPIO or address use for each pin. A direction register picks input or output for each GPIO pin. A data register holds the levels driven out, and reads back the pad levels of the pins that are not driving.

The GPIO selection takes effect only while a 2-bit bus-mode input holds one of two codes. For the other codes every line carries the controller's address. A parameter mask marks the pins that do not exist on a given package. Their select bits always read 0 and cannot be set, so those lines stay address outputs. Pad inputs cross a two-flop synchronizer before they reach the read path.

Top module: `addr_gpio_mux`

## Requirements
- R1: After reset the select, direction and data registers are all 0 and every pin is in address mode: pad_oe is all ones and pad_out equals ctrl_addr.
- R2: A pin whose select bit is 0 has pad_oe = 1 and pad_out equal to its ctrl_addr bit.
- R3: GPIO use is honoured only while bus_mode is 2'b00 or 2'b11. With 2'b01 or 2'b10, every pin has pad_oe = 1 and pad_out = ctrl_addr, whatever the registers hold.
- R4: A selected GPIO pin whose direction bit is 0 (input) has pad_oe = 0.
- R5: A selected GPIO pin whose direction bit is 1 (output) has pad_oe = 1 and pad_out equal to its data register bit.
- R6: A data-register read returns, for every pin not in GPIO output mode, the pad_in level that was sampled two clock edges before the edge that performs the read.
- R7: Data bits written while a pin is not in GPIO output mode are kept. They are driven on pad_out as soon as the pin becomes a GPIO output.
- R8: A pin whose bit is 0 in PIN_PRESENT (default 16'h3FFF, so pins 14 and 15 are absent) has a select bit that reads 0. Writes to that bit are ignored, and the pin remains an address output.
- R9: An access with reg_en = 1 uses reg_sel 0 for select, 1 for direction, 2 for data and 3 for nothing (writes are ignored, reads return 0). Read data appears on reg_rdata after the access edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | Register word select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| bus_mode | input | 2 | Parallel-port mode field |
| ctrl_addr | input | 16 | Address from the memory controller |
| pad_in | input | 16 | Levels sampled from the pads |
| pad_out | output | 16 | Level driven to each pad |
| pad_oe | output | 16 | Pad output enable, 1 = drive |

## Verification
Any corrupted select or direction bit shows on pad_oe or pad_out in the same cycle, because the pad multiplexer is combinational from the registers and the mode input. A wrong data bit in a non-driving pin stays hidden until that pin becomes an output, so the sequence writes data first and turns the pin around afterwards. Synchronizer errors show up one read later, as a level that arrives one cycle early or one cycle late. The reference model therefore reads the data register on back-to-back cycles around every pad change.

// File: rtl/agm_pkg.sv
package agm_pkg;
    typedef enum logic [1:0] {
        SEL_EN   = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DAT  = 2'd2,
        SEL_NONE = 2'd3
    } agm_sel_e;

    function automatic logic gpio_mode_ok(input logic [1:0] mode);
        return (mode == 2'b00) || (mode == 2'b11);
    endfunction
endpackage

// File: rtl/agm_sync.sv
module agm_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

    p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && STAGES == 2) |-> sync_out == $past(async_in, 2))
        else $error("sync delay");
endmodule

// File: rtl/agm_padmux.sv
module agm_padmux #(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] sel_gpio,
    input  logic [W-1:0] dir_out,
    input  logic [W-1:0] dat,
    input  logic [W-1:0] addr,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] out_mode
);
    import agm_pkg::*;

    logic mode_ok;
    assign mode_ok = gpio_mode_ok(mode);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic gpio_on;
        assign gpio_on     = mode_ok & sel_gpio[i];
        assign out_mode[i] = gpio_on & dir_out[i];
        assign pad_oe[i]   = gpio_on ? dir_out[i] : 1'b1;
        assign pad_out[i]  = gpio_on ? dat[i] : addr[i];
    end
endmodule

// File: rtl/agm_regs.sv
module agm_regs #(
    parameter int           W       = 16,
    parameter logic [W-1:0] PRESENT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic         acc_wr,
    input  logic [1:0]   acc_sel,
    input  logic [W-1:0] acc_wdata,
    input  logic [W-1:0] out_mode,
    input  logic [W-1:0] sync_lvl,
    output logic [W-1:0] en_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] rdata
);
    import agm_pkg::*;

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] dir;
        logic [W-1:0] dat;
        logic [W-1:0] rd;
    } regs_t;

    regs_t st_d, st_q;
    logic [W-1:0] dat_view;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++)
            dat_view[i] = out_mode[i] ? st_q.dat[i] : sync_lvl[i];
        if (acc_en && acc_wr) begin
            case (agm_sel_e'(acc_sel))
                SEL_EN:  st_d.en  = acc_wdata & PRESENT;
                SEL_DIR: st_d.dir = acc_wdata;
                SEL_DAT: st_d.dat = acc_wdata;
                default: ;
            endcase
        end
        if (acc_en && !acc_wr) begin
            case (agm_sel_e'(acc_sel))
                SEL_EN:  st_d.rd = st_q.en;
                SEL_DIR: st_d.rd = st_q.dir;
                SEL_DAT: st_d.rd = dat_view;
                default: st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign dir_q = st_q.dir;
    assign dat_q = st_q.dat;
    assign rdata = st_q.rd;

    p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_sel == 2'd0) |=> en_q == ($past(acc_wdata) & PRESENT))
        else $error("select write");
    p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~PRESENT) == '0)
        else $error("absent select bit set");
endmodule

// File: rtl/addr_gpio_mux.sv
module addr_gpio_mux #(
    parameter int                 NPINS       = 16,
    parameter logic [NPINS-1:0]   PIN_PRESENT = 16'h3FFF,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] reg_rdata,
    input  logic [1:0]       bus_mode,
    input  logic [NPINS-1:0] ctrl_addr,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    logic [NPINS-1:0] en_w, dir_w, dat_w, sync_w, outm_w;

    agm_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(sync_w)
    );

    agm_regs #(.W(NPINS), .PRESENT(PIN_PRESENT)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(reg_en), .acc_wr(reg_wr),
        .acc_sel(reg_sel), .acc_wdata(reg_wdata), .out_mode(outm_w),
        .sync_lvl(sync_w), .en_q(en_w), .dir_q(dir_w), .dat_q(dat_w),
        .rdata(reg_rdata)
    );

    agm_padmux #(.W(NPINS)) u_mux (
        .mode(bus_mode), .sel_gpio(en_w), .dir_out(dir_w), .dat(dat_w),
        .addr(ctrl_addr), .pad_out(pad_out), .pad_oe(pad_oe), .out_mode(outm_w)
    );

    p_mode_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 2'b01 || bus_mode == 2'b10) |-> (pad_oe == '1 && pad_out == ctrl_addr))
        else $error("mode gate");
    p_absent_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~PIN_PRESENT) == ~PIN_PRESENT) &&
        ((pad_out & ~PIN_PRESENT) == (ctrl_addr & ~PIN_PRESENT)))
        else $error("absent pin left address mode");
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_wr) |=> $stable(reg_rdata))
        else $error("read data moved");
    p_input_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (outm_w == '0 && en_w != '0 && (bus_mode == 2'b00 || bus_mode == 2'b11))
        |-> ((pad_oe & en_w) == '0))
        else $error("input pin driving");
endmodule

// File: tb/addr_gpio_mux_tb.sv
module addr_gpio_mux_tb;
    localparam int          W    = 16;
    localparam logic [15:0] MASK = 16'h3FFF;

    logic clk = 0, rst_n = 0;
    logic reg_en = 0, reg_wr = 0;
    logic [1:0] reg_sel = 0, bus_mode = 0;
    logic [W-1:0] reg_wdata = 0, ctrl_addr = 0, pad_in = 0;
    logic [W-1:0] reg_rdata, pad_out, pad_oe;

    always #4 clk = ~clk;

    addr_gpio_mux u_dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_mode(bus_mode), .ctrl_addr(ctrl_addr), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // reference state
    logic [W-1:0] m_en, m_dir, m_dat, m_s1, m_s2, m_rd;
    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    function automatic logic mode_ok(input logic [1:0] m);
        return m == 2'b00 || m == 2'b11;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_en <= 0; m_dir <= 0; m_dat <= 0; m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
        end else begin
            if (reg_en && reg_wr) begin
                if (reg_sel == 0) m_en  <= reg_wdata & MASK;
                if (reg_sel == 1) m_dir <= reg_wdata;
                if (reg_sel == 2) m_dat <= reg_wdata;
            end
            if (reg_en && !reg_wr) begin
                case (reg_sel)
                    2'd0: m_rd <= m_en;
                    2'd1: m_rd <= m_dir;
                    2'd2: for (int i = 0; i < W; i++)
                              m_rd[i] <= (mode_ok(bus_mode) && m_en[i] && m_dir[i]) ? m_dat[i] : m_s2[i];
                    default: m_rd <= 0;
                endcase
            end
            m_s1 <= pad_in;
            m_s2 <= m_s1;
        end
    end

    task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [W-1:0] e_oe, e_out;
        for (int i = 0; i < W; i++) begin
            logic g;
            g = rst_n && mode_ok(bus_mode) && m_en[i];
            e_oe[i]  = g ? m_dir[i] : 1'b1;
            e_out[i] = g ? (m_dir[i] ? m_dat[i] : pad_out[i]) : ctrl_addr[i];
        end
        chk("pad_oe", pad_oe, e_oe);
        chk("pad_out", pad_out & e_oe, e_out & e_oe);
        if (rst_n) chk("reg_rdata", reg_rdata, m_rd);
    end

    task automatic step();
        @(posedge clk); #2;
        reg_en = 0;
        ctrl_addr = W'($urandom);
    endtask
    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        step(); reg_en = 1; reg_wr = 1; reg_sel = s; reg_wdata = d;
    endtask
    task automatic rd(input logic [1:0] s);
        step(); reg_en = 1; reg_wr = 0; reg_sel = s;
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(4); rst_n = 1;
        rd(0); rd(1); rd(2); idle(2);
        // R2: disabled pins follow the address
        cur_req = "R2"; bus_mode = 2'b00; idle(6);
        // R9 / R8: register map and absent pins
        cur_req = "R8"; wr(0, 16'hFFFF); rd(0); idle(2);
        cur_req = "R9"; wr(1, 16'h00FF); wr(2, 16'hA5A5); rd(1); rd(2); idle(1);
        wr(3, 16'hFFFF); rd(3); rd(0); rd(1); idle(3);
        // R4 / R5: mixed directions, both permitted modes
        cur_req = "R4"; pad_in = 16'h1234; idle(3); rd(2); idle(1);
        cur_req = "R5"; bus_mode = 2'b11; pad_in = 16'hFEDC; idle(3); rd(2); idle(1);
        // R3: forbidden modes
        cur_req = "R3"; bus_mode = 2'b01; idle(4); rd(2); idle(1);
        bus_mode = 2'b10; idle(4); bus_mode = 2'b00; idle(1);
        // R6: synchronizer latency, back-to-back reads
        cur_req = "R6"; wr(1, 16'h0000);
        for (int k = 0; k < 6; k++) begin
            step(); pad_in = W'($urandom); reg_en = 1; reg_wr = 0; reg_sel = 2;
            rd(2); rd(2);
        end
        idle(2);
        // R7: data kept while input, shown once turned to output
        cur_req = "R7"; wr(2, 16'h3C96); idle(2); rd(2);
        wr(1, 16'hFFFF); idle(2); rd(2); idle(1);
        wr(0, 16'h0F0F); idle(3); wr(0, 16'hFFFF); idle(3);
        cur_req = "R2"; wr(0, 16'h0000); idle(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule